// File: doc/BRIEF.md
# Bidirectional Timer with Two Compare Channels

An 8-bit timer/counter that steps once for each enabled tick, either upward or alternately up and down. Its end-of-count value is either the full-scale value 0xFF or the buffered value of compare channel A, depending on the mode. Two compare channels watch the count. Each one raises a match flag and drives a waveform pin. The waveform pins serve plain event signalling, clear-on-match period generation, single-slope PWM and dual-slope (phase-correct) PWM.

Software sets the block up through a write-only register port. The port accepts a control word, a direct count load, two compare values, an interrupt mask, and a flag-clear register in which writing a one clears that flag. The divider chain that produces ticks sits outside the block. It delivers `tick_i` as a one-cycle pulse. A tick only takes effect while the clock-enable bit of the control word is set.

Register map (address on `wr_addr_i`): 0 control, 1 count, 2 compare A, 3 compare B, 4 interrupt mask, 5 flag clear. Control word bits: [1:0] mode (0 normal, 1 clear-on-match-A, 2 single-slope PWM, 3 dual-slope PWM), [2] end-of-count select for the PWM modes (0 = 0xFF, 1 = compare A), [3] clock enable, [5:4] action for waveform A, [7:6] action for waveform B. The action codes are 0 off (pin held low), 1 toggle on match, 2 non-inverting, 3 inverting. Flag and mask bits: [0] overflow, [1] match A, [2] match B.

Top module: `bidir_timer`

## Requirements
- R1: After reset the count, all flags, both waveform pins and `irq_o` are 0, and the control word is 0 (clock disabled).
- R2: The count does not change while control bit 3 is 0, or on cycles without `tick_i`.
- R3: In normal mode (0) each step adds one to the count. A step taken at 0xFF gives 0x00 and sets flag bit 0.
- R4: In mode 1, a step taken while the count equals buffered compare A loads 0.
- R5: In mode 2, a step taken at end-of-count (or at 0xFF) loads 0 and sets flag bit 0. With action 2 the pin goes high at that wrap and low on a match.
- R6: In mode 3 the count rises to end-of-count and then falls to 0. A step taken at 0 while falling loads 1 and sets flag bit 0. With action 2 the pin goes low on a rising match and high on a falling match.
- R7: In modes 2 and 3 a compare write is held and moves into the active compare value only at end-of-count. In modes 0 and 1 it takes effect at once.
- R8: A step taken while the count equals a channel's active compare value sets that channel's flag (bit 1 for A, bit 2 for B).
- R9: After a count load, the next step raises no compare match, even when the loaded value equals a compare value.
- R10: Writing a one to a bit at address 5 clears that flag. If a flag is set in the same cycle, it stays set.
- R11: `irq_o` is high exactly when some flag bit and its mask bit (address 4) are both 1.
- R12: Action 1 toggles the pin on each match, and action 0 holds the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle prescaled tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW (3) | Register address |
| wr_data_i | input | CW (8) | Write data |
| count_o | output | CW (8) | Current count |
| flags_o | output | 3 | Flags: overflow, match A, match B |
| irq_o | output | 1 | Masked interrupt request |
| wave_o | output | 2 | Waveform pins A (bit 0) and B (bit 1) |

## Verification
The bench uses the default parameters, CW = 8 and AW = 3. With these the 0xFF wrap is reached within a few ticks of a count load near full scale. With small compare values (2 to 4) as end-of-count, every mode completes whole periods in a handful of ticks. That puts these corner cases within reach in short directed scenarios: the flag set that overrides a clear in the same cycle, the match suppressed after a count load, the buffered compare update at end-of-count, and the dual-slope turn at both ends.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_CTC    = 2'd1,
    MODE_FAST   = 2'd2,
    MODE_PHASE  = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    WAVE_OFF    = 2'd0,
    WAVE_TOGGLE = 2'd1,
    WAVE_CLEAR  = 2'd2,
    WAVE_SET    = 2'd3
  } wave_act_e;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CNT  = 1;
  localparam int ADDR_OCR0 = 2;
  localparam int ADDR_MASK = 4;
  localparam int ADDR_FLAG = 5;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input  tmr_mode_e       mode_i,
  input  logic            top_sel_i,
  input  logic            step_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic            dir_down_i,
  input  logic [CW-1:0]   ocra_i,
  output logic [CW-1:0]   top_o,
  output logic [CW-1:0]   cnt_nxt_o,
  output logic            dir_down_nxt_o,
  output logic            ovf_evt_o,
  output logic            upd_evt_o,
  output logic            bottom_evt_o,
  output logic            pwm_o
);
  localparam logic [CW-1:0] MAX = '1;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic ovf, upd, bottom, wrap;

  assign pwm_o = (mode_i == MODE_FAST) || (mode_i == MODE_PHASE);
  assign top_o = ((mode_i == MODE_CTC) || (pwm_o && top_sel_i)) ? ocra_i : MAX;
  assign wrap  = (cnt_i == top_o) || (cnt_i == MAX);

  always_comb begin
    cnt_nxt_o      = cnt_i + 1'b1;
    dir_down_nxt_o = 1'b0;
    ovf            = 1'b0;
    upd            = 1'b0;
    bottom         = 1'b0;
    unique case (mode_i)
      MODE_NORMAL: ovf = (cnt_i == MAX);
      MODE_CTC: begin
        ovf = (cnt_i == MAX);
        if (cnt_i == top_o) cnt_nxt_o = '0;
      end
      MODE_FAST: begin
        if (wrap) begin
          cnt_nxt_o = '0;
          ovf       = 1'b1;
          upd       = 1'b1;
          bottom    = 1'b1;
        end
      end
      MODE_PHASE: begin
        if (!dir_down_i) begin
          if (cnt_i >= top_o) begin
            dir_down_nxt_o = 1'b1;
            upd            = 1'b1;
            cnt_nxt_o      = (cnt_i == '0) ? '0 : cnt_i - 1'b1;
          end
        end else if (cnt_i == '0) begin
          ovf       = 1'b1;
          cnt_nxt_o = (top_o == '0) ? '0 : ONE;
        end else begin
          dir_down_nxt_o = 1'b1;
          cnt_nxt_o      = cnt_i - 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign ovf_evt_o    = step_i & ovf;
  assign upd_evt_o    = step_i & upd;
  assign bottom_evt_o = step_i & bottom;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          phase_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic          dir_down_nxt_i,
  output logic [CW-1:0] cnt_o,
  output logic          dir_down_o,
  output logic          blk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o      <= '0;
      dir_down_o <= 1'b0;
      blk_o      <= 1'b0;
    end else begin
      if (load_i) begin
        cnt_o <= load_val_i;
        blk_o <= 1'b1;
      end else if (step_i) begin
        cnt_o      <= cnt_nxt_i;
        dir_down_o <= dir_down_nxt_i;
        blk_o      <= 1'b0;
      end
      if (!phase_i) dir_down_o <= 1'b0;
    end
  end

  // R2: no step and no load keeps the count
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          pwm_i,
  input  logic          upd_i,
  input  logic          step_i,
  input  logic          blk_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dir_down_i,
  input  tmr_mode_e     mode_i,
  input  wave_act_e     act_i,
  input  logic          bottom_i,
  output logic [CW-1:0] buf_o,
  output logic          match_o,
  output logic          wave_o
);
  logic [CW-1:0] wreg_q;
  logic          wave_q;

  assign match_o = step_i & ~blk_i & (cnt_i == buf_o);
  assign wave_o  = (act_i != WAVE_OFF) & wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wreg_q <= '0;
      buf_o  <= '0;
    end else begin
      if (wr_i) wreg_q <= wr_data_i;
      if (!pwm_i)     buf_o <= wr_i ? wr_data_i : wreg_q;
      else if (upd_i) buf_o <= wreg_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
    end else if (act_i == WAVE_OFF) begin
      wave_q <= 1'b0;
    end else if ((mode_i == MODE_FAST) && bottom_i && (act_i != WAVE_TOGGLE)) begin
      wave_q <= (act_i == WAVE_CLEAR);
    end else if (match_o) begin
      unique case (act_i)
        WAVE_TOGGLE: wave_q <= ~wave_q;
        WAVE_CLEAR:  wave_q <= (mode_i == MODE_PHASE) ? dir_down_i : 1'b0;
        WAVE_SET:    wave_q <= (mode_i == MODE_PHASE) ? ~dir_down_i : 1'b1;
        default:     wave_q <= wave_q;
      endcase
    end
  end

  // R7: in PWM modes the active compare value moves only at end-of-count
  a_r7_buf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !upd_i) |=> $stable(buf_o));
endmodule

// File: rtl/bidir_timer.sv
module bidir_timer
  import tmr_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  output logic [CW-1:0] count_o,
  output logic [2:0]    flags_o,
  output logic          irq_o,
  output logic [1:0]    wave_o
);
  localparam int NCH = 2;
  localparam int NF  = NCH + 1;

  logic [7:0]    ctrl_q;
  logic [NF-1:0] mask_q, flags_q, set_vec, clr_vec;
  tmr_mode_e     mode;
  logic          step, cnt_wr, pwm, upd_evt, ovf_evt, bottom_evt;
  logic          dir_down, dir_down_nxt, blk;
  logic [CW-1:0] cnt_q, cnt_nxt, top_val;
  logic [CW-1:0] ocr_buf [NCH];
  logic [NCH-1:0] match;

  assign mode   = tmr_mode_e'(ctrl_q[1:0]);
  assign step   = tick_i & ctrl_q[3];
  assign cnt_wr = wr_en_i && (wr_addr_i == AW'(ADDR_CNT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == AW'(ADDR_CTRL)) ctrl_q <= wr_data_i[7:0];
      if (wr_addr_i == AW'(ADDR_MASK)) mask_q <= wr_data_i[NF-1:0];
    end
  end

  tmr_ctrl #(.CW(CW)) u_ctrl (
    .mode_i         (mode),
    .top_sel_i      (ctrl_q[2]),
    .step_i         (step),
    .cnt_i          (cnt_q),
    .dir_down_i     (dir_down),
    .ocra_i         (ocr_buf[0]),
    .top_o          (top_val),
    .cnt_nxt_o      (cnt_nxt),
    .dir_down_nxt_o (dir_down_nxt),
    .ovf_evt_o      (ovf_evt),
    .upd_evt_o      (upd_evt),
    .bottom_evt_o   (bottom_evt),
    .pwm_o          (pwm)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .step_i         (step),
    .phase_i        (mode == MODE_PHASE),
    .load_i         (cnt_wr),
    .load_val_i     (wr_data_i),
    .cnt_nxt_i      (cnt_nxt),
    .dir_down_nxt_i (dir_down_nxt),
    .cnt_o          (cnt_q),
    .dir_down_o     (dir_down),
    .blk_o          (blk)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_compare #(.CW(CW)) u_cmp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_en_i && (wr_addr_i == AW'(ADDR_OCR0 + i))),
      .wr_data_i  (wr_data_i),
      .pwm_i      (pwm),
      .upd_i      (upd_evt),
      .step_i     (step),
      .blk_i      (blk),
      .cnt_i      (cnt_q),
      .dir_down_i (dir_down),
      .mode_i     (mode),
      .act_i      (wave_act_e'(ctrl_q[4+2*i +: 2])),
      .bottom_i   (bottom_evt),
      .buf_o      (ocr_buf[i]),
      .match_o    (match[i]),
      .wave_o     (wave_o[i])
    );
  end

  assign set_vec = {match, ovf_evt};
  assign clr_vec = (wr_en_i && (wr_addr_i == AW'(ADDR_FLAG))) ? wr_data_i[NF-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_vec) | set_vec;
  end

  assign count_o = cnt_q;
  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & mask_q);

  // R3: full-scale wrap in normal mode
  a_r3_wrap_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_NORMAL && step && !cnt_wr && cnt_q == '1) |=> (cnt_q == '0 && flags_q[0]));

  // R4: clear on compare A
  a_r4_ctc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_CTC && step && !cnt_wr && cnt_q == ocr_buf[0]) |=> (cnt_q == '0));

  // R6: turn at bottom
  a_r6_turn_bottom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_PHASE && step && !cnt_wr && dir_down && cnt_q == '0 && top_val != '0)
    |=> (cnt_q == CW'(1) && !dir_down && flags_q[0]));

  // R10: a set beats a clear in the same cycle
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: tb/tb_bidir_timer.sv
module tb_bidir_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count;
  logic [2:0] flags;
  logic       irq;
  logic [1:0] wave;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bidir_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .count_o(count),
    .flags_o(flags), .irq_o(irq), .wave_o(wave)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R1 count", count, 0);
    chk("R1 flags", flags, 0);
    chk("R1 wave", wave, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_clock_off;
    tk(5);
    chk("R2 clock off", count, 0);
    wr(3'd0, 8'h08);
    repeat (5) @(negedge clk);
    chk("R2 no tick", count, 0);
    tk(1);
    chk("R2 tick on", count, 1);
  endtask

  task automatic t_normal_flags;
    wr(3'd1, 8'hFD);
    tk(2);
    chk("R3 at max", count, 8'hFF);
    chk("R3 no ovf yet", flags[0], 0);
    tk(1);
    chk("R3 wrap", count, 0);
    chk("R3 ovf", flags[0], 1);
    wr(3'd5, 8'h01);
    chk("R10 clear", flags[0], 0);
    wr(3'd1, 8'hFF);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h01;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R10 set wins", flags[0], 1);
  endtask

  task automatic t_match_irq;
    wr(3'd3, 8'd5);
    wr(3'd5, 8'h07);
    wr(3'd1, 8'd3);
    tk(2);
    chk("R8 before match", flags[2], 0);
    tk(1);
    chk("R8 match B", flags[2], 1);
    chk("R11 masked", irq, 0);
    wr(3'd4, 8'h04);
    chk("R11 enabled", irq, 1);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_load_block;
    wr(3'd2, 8'd7);
    wr(3'd5, 8'h07);
    wr(3'd1, 8'd7);
    tk(1);
    chk("R9 count", count, 8);
    chk("R9 no match", flags[1], 0);
    wr(3'd1, 8'd6);
    tk(2);
    chk("R9 later match", flags[1], 1);
  endtask

  task automatic t_ctc;
    wr(3'd0, 8'h19);
    wr(3'd2, 8'd3);
    wr(3'd1, 8'd0);
    wr(3'd5, 8'h07);
    tk(3);
    chk("R4 reach", count, 3);
    tk(1);
    chk("R4 clear", count, 0);
    chk("R12 toggle", wave[0], 1);
    chk("R12 off", wave[1], 0);
    chk("R8 match A", flags[1], 1);
    wr(3'd2, 8'd2);
    tk(2);
    chk("R7 immediate", count, 2);
    tk(1);
    chk("R7 new clear", count, 0);
    chk("R12 toggle back", wave[0], 0);
  endtask

  task automatic t_fast;
    wr(3'd0, 8'h08);
    wr(3'd2, 8'd4);
    wr(3'd3, 8'd2);
    wr(3'd1, 8'd0);
    wr(3'd5, 8'h07);
    wr(3'd0, 8'h8E);
    tk(5);
    chk("R5 wrap", count, 0);
    chk("R5 set at bottom", wave[1], 1);
    chk("R5 ovf", flags[0], 1);
    tk(2);
    chk("R5 high", wave[1], 1);
    tk(1);
    chk("R5 clear on match", wave[1], 0);
    wr(3'd3, 8'd3);
    tk(2);
    chk("R7 wrap", count, 0);
    chk("R7 set", wave[1], 1);
    tk(3);
    chk("R7 old value gone", wave[1], 1);
    tk(1);
    chk("R7 new value", wave[1], 0);
  endtask

  task automatic t_phase;
    wr(3'd0, 8'h08);
    wr(3'd2, 8'd3);
    wr(3'd3, 8'd1);
    wr(3'd1, 8'd0);
    wr(3'd5, 8'h07);
    wr(3'd0, 8'h8F);
    tk(4);
    chk("R6 turn at top", count, 2);
    chk("R6 up match clears", wave[1], 0);
    tk(2);
    chk("R6 bottom", count, 0);
    chk("R6 down match sets", wave[1], 1);
    chk("R6 no ovf yet", flags[0], 0);
    tk(1);
    chk("R6 turn up", count, 1);
    chk("R6 ovf", flags[0], 1);
    tk(1);
    chk("R6 up match again", wave[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clock_off();
    t_normal_flags();
    t_match_irq();
    t_load_block();
    t_ctc();
    t_fast();
    t_phase();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule